// File: doc/BRIEF.md
# Two-Class Weighted Round-Robin Transmit DMA Arbiter

This block decides which of several transmit FIFOs gets the shared DMA engine next. A FIFO competes only when its transmit queue has a pending request and it has free space. Every FIFO sits in one of two speed groups, fixed by a parameter. A programmable bit per FIFO puts it in the high or low class of its group. Within a group, high-class FIFOs are served round-robin. Low-class FIFOs are served round-robin only when no high-class FIFO of that group is eligible. When both groups have work, a programmable grant ratio decides which group goes next.

A grant covers one packet. A packet may span many DMA requests. Once issued, the grant stays locked on its FIFO until that FIFO strobes packet-done. A small register port holds the class bits and the two ratio counts. The grant is a plain one-hot vector with a valid flag. It has no ready handshake, because the release is the owner's packet-done strobe.

Top module: `dma_txfifo_arb`

## Requirements
- R1: After reset the grant is zero and grant_vld is low. Address 0 reads 0 (all FIFOs low class). Address 1 reads 32'h0000_0101 (both ratio counts 1).
- R2: Only a FIFO with req_pend=1 and space_ok=1 is eligible. With no eligible FIFO, grant_vld stays low.
- R3: grant is one-hot when grant_vld is high and all-zero when it is low.
- R4: A grant appears on the clock edge after an unlocked cycle in which some FIFO is eligible. It then holds unchanged, whatever the inputs do, until pkt_done of the owner is sampled high. The cycle after that, grant_vld is low.
- R5: A pkt_done bit of a FIFO that does not hold the grant has no effect.
- R6: Within the selected group, an eligible high-class FIFO (priority bit n = 1) always wins over eligible low-class FIFOs.
- R7: Among the candidates of one class in one group, the search starts at that class's pointer and goes upward with wrap-around. When the owner's packet completes, that pointer moves to the owner's index plus one, modulo the FIFO count.
- R8: Each group keeps separate pointers for its high and low class. Completing a packet moves only the pointer of the owner's group and of its class as it was at grant time.
- R9: Address 1 bits [3:0] hold count A and bits [11:8] hold count B. FIFOs whose bit is clear in GROUP_B_MASK form group A. If both groups stay eligible, grants follow A repeated count-A times, then B repeated count-B times, starting with A after reset.
- R10: If only one group has an eligible FIFO, that group is granted, and the ratio state does not change.
- R11: Address 0 bits [6:0] are the read/write class bits, and its upper bits read 0. At address 1, writing a count of 0 stores 1, and the bits outside the two count fields read 0.
- R12: A class-bit write while a grant is locked leaves that grant unchanged. The new value is used at the next decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 1 | Register select (0 class bits, 1 ratio) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| req_pend | input | NUM_FIFO | Per-FIFO transmit queue holds a DMA request |
| space_ok | input | NUM_FIFO | Per-FIFO free space available |
| pkt_done | input | NUM_FIFO | Per-FIFO packet-complete strobe |
| grant | output | NUM_FIFO | One-hot grant |
| grant_vld | output | 1 | A grant is held |

## Verification
The hardest state to reach is a ratio counter in the middle of its count, combined with class pointers left at arbitrary positions in both groups. That mix only builds up over long runs of packets in which the class bits and the eligibility patterns keep changing. The bench runs a long pseudo-random sequence of packets and rewrites the class bits and the ratio counts between packets. A bench-side model, built from the requirements, tracks the pointers and the ratio state and gives the expected winner of every decision. Directed phases then reach a locked grant disturbed by foreign strobes, dropped requests and class writes, as well as a clean ratio sequence started from reset.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {GRP_A = 1'b0, GRP_B = 1'b1} grp_e;
  typedef enum logic {CLS_LO = 1'b0, CLS_HI = 1'b1} cls_e;
  localparam int unsigned CFG_DW = 32;
  localparam int unsigned QB_LSB = 8;
endpackage

// File: rtl/dma_arb_regs.sv
module dma_arb_regs
  import dma_arb_pkg::*;
#(
  parameter int unsigned NF = 7,
  parameter int unsigned RW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              addr,
  input  logic [CFG_DW-1:0] wdata,
  output logic [CFG_DW-1:0] rdata,
  output logic [NF-1:0]     prio,
  output logic [RW-1:0]     quota_a,
  output logic [RW-1:0]     quota_b
);
  localparam logic [RW-1:0] ONE = RW'(1);

  logic [RW-1:0] wa, wb;
  assign wa = wdata[RW-1:0];
  assign wb = wdata[QB_LSB +: RW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio    <= '0;
      quota_a <= ONE;
      quota_b <= ONE;
    end else if (we) begin
      if (!addr) begin
        prio <= wdata[NF-1:0];
      end else begin
        quota_a <= (wa == '0) ? ONE : wa;
        quota_b <= (wb == '0) ? ONE : wb;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (!addr) begin
      rdata[NF-1:0] = prio;
    end else begin
      rdata[RW-1:0]        = quota_a;
      rdata[QB_LSB +: RW]  = quota_b;
    end
  end
endmodule

// File: rtl/dma_arb_rr_pick.sv
module dma_arb_rr_pick #(
  parameter int unsigned NF = 7,
  parameter int unsigned IW = 3
) (
  input  logic [NF-1:0] mask,
  input  logic [IW-1:0] ptr,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < int'(NF); k++) begin
      int j;
      j = int'(ptr) + k;
      if (j >= int'(NF)) j = j - int'(NF);
      if (!found && mask[j]) begin
        found = 1'b1;
        idx   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/dma_arb_group_sel.sv
module dma_arb_group_sel #(
  parameter int unsigned RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_a,
  input  logic          any_b,
  input  logic          take,
  input  logic [RW-1:0] quota_a,
  input  logic [RW-1:0] quota_b,
  output logic          pick_b
);
  logic          turn_b;
  logic [RW-1:0] cnt;
  logic [RW:0]   cnt_nx;
  logic [RW:0]   quota_cur;

  assign pick_b    = any_b && (!any_a || turn_b);
  assign cnt_nx    = {1'b0, cnt} + 1'b1;
  assign quota_cur = turn_b ? {1'b0, quota_b} : {1'b0, quota_a};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      turn_b <= 1'b0;
      cnt    <= '0;
    end else if (take && any_a && any_b) begin
      if (cnt_nx >= quota_cur) begin
        turn_b <= ~turn_b;
        cnt    <= '0;
      end else begin
        cnt <= cnt_nx[RW-1:0];
      end
    end
  end
endmodule

// File: rtl/dma_txfifo_arb.sv
module dma_txfifo_arb
  import dma_arb_pkg::*;
#(
  parameter int unsigned       NUM_FIFO     = 7,
  parameter int unsigned       RATIO_W      = 4,
  parameter logic [NUM_FIFO-1:0] GROUP_B_MASK = 7'b1111000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic [NUM_FIFO-1:0] req_pend,
  input  logic [NUM_FIFO-1:0] space_ok,
  input  logic [NUM_FIFO-1:0] pkt_done,
  output logic [NUM_FIFO-1:0] grant,
  output logic                grant_vld
);
  localparam int unsigned IW    = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1;
  localparam int unsigned SLOTS = 4;  // {group, class}

  logic [NUM_FIFO-1:0] prio;
  logic [RATIO_W-1:0]  quota_a, quota_b;
  logic [NUM_FIFO-1:0] elig;

  logic [SLOTS-1:0][NUM_FIFO-1:0] cand;
  logic [SLOTS-1:0][IW-1:0]       ptr_q;
  logic [SLOTS-1:0][IW-1:0]       hit_idx;
  logic [SLOTS-1:0]               hit;

  logic    any_a, any_b, pick_b, take;
  logic [IW-1:0] win_idx;
  cls_e    win_cls;

  logic    locked;
  logic [IW-1:0] own_idx;
  cls_e    own_cls;
  grp_e    own_grp;
  logic    done_hit;
  logic [IW-1:0] own_nxt;

  dma_arb_regs #(.NF(NUM_FIFO), .RW(RATIO_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .rdata   (cfg_rdata),
    .prio    (prio),
    .quota_a (quota_a),
    .quota_b (quota_b)
  );

  assign elig = req_pend & space_ok;

  for (genvar s = 0; s < int'(SLOTS); s++) begin : g_slot
    localparam logic [NUM_FIFO-1:0] GMASK = (s >= 2) ? GROUP_B_MASK : ~GROUP_B_MASK;
    localparam bit HI = (s % 2) == 1;
    assign cand[s] = elig & GMASK & (HI ? prio : ~prio);
    dma_arb_rr_pick #(.NF(NUM_FIFO), .IW(IW)) u_pick (
      .mask  (cand[s]),
      .ptr   (ptr_q[s]),
      .found (hit[s]),
      .idx   (hit_idx[s])
    );
  end

  assign any_a = hit[0] | hit[1];
  assign any_b = hit[2] | hit[3];
  assign take  = !locked && (any_a || any_b);

  dma_arb_group_sel #(.RW(RATIO_W)) u_gsel (
    .clk     (clk),
    .rst_n   (rst_n),
    .any_a   (any_a),
    .any_b   (any_b),
    .take    (take),
    .quota_a (quota_a),
    .quota_b (quota_b),
    .pick_b  (pick_b)
  );

  always_comb begin
    if (hit[{pick_b, 1'b1}]) begin
      win_idx = hit_idx[{pick_b, 1'b1}];
      win_cls = CLS_HI;
    end else begin
      win_idx = hit_idx[{pick_b, 1'b0}];
      win_cls = CLS_LO;
    end
  end

  assign done_hit = locked && pkt_done[own_idx];
  assign own_nxt  = (own_idx == IW'(NUM_FIFO - 1)) ? '0 : own_idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked  <= 1'b0;
      own_idx <= '0;
      own_cls <= CLS_LO;
      own_grp <= GRP_A;
    end else if (take) begin
      locked  <= 1'b1;
      own_idx <= win_idx;
      own_cls <= win_cls;
      own_grp <= pick_b ? GRP_B : GRP_A;
    end else if (done_hit) begin
      locked <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (done_hit) begin
      for (int s = 0; s < int'(SLOTS); s++) begin
        if (2'(s) == {own_grp, own_cls}) ptr_q[s] <= own_nxt;
      end
    end
  end

  assign grant     = locked ? (NUM_FIFO'(1) << own_idx) : '0;
  assign grant_vld = locked;
endmodule

// File: rtl/dma_txfifo_arb_chk.sv
module dma_txfifo_arb_chk #(
  parameter int unsigned NF = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NF-1:0] req_pend,
  input logic [NF-1:0] space_ok,
  input logic [NF-1:0] pkt_done,
  input logic [NF-1:0] grant,
  input logic          grant_vld
);
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld ? $onehot(grant) : (grant == '0)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && ((pkt_done & grant) == '0)) |=> (grant_vld && grant == $past(grant)));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && ((pkt_done & grant) != '0)) |=> !grant_vld);

  p_foreign_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && pkt_done != '0 && ((pkt_done & grant) == '0)) |=> grant_vld);

  p_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld && ((req_pend & space_ok) == '0)) |=> !grant_vld);

  p_first_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld && ((req_pend & space_ok) != '0)) |=> ((grant & $past(req_pend & space_ok)) != '0));

  p_no_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld && ((req_pend & space_ok) != '0)) |=> grant_vld);
endmodule

bind dma_txfifo_arb dma_txfifo_arb_chk #(.NF(NUM_FIFO)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_pend  (req_pend),
  .space_ok  (space_ok),
  .pkt_done  (pkt_done),
  .grant     (grant),
  .grant_vld (grant_vld)
);

// File: tb/sim_dma_txfifo_arb.sv
module sim_dma_txfifo_arb;
  localparam int NF = 7;
  localparam logic [NF-1:0] GB = 7'b1111000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic          cfg_addr = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic [NF-1:0] req_pend = '0;
  logic [NF-1:0] space_ok = '0;
  logic [NF-1:0] pkt_done = '0;
  logic [NF-1:0] grant;
  logic          grant_vld;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  // model state
  int mptr[4];
  int mturn, mcnt, qa, qb;
  logic [NF-1:0] mprio;
  int mwin, mslot;

  always #4 clk = ~clk;

  dma_txfifo_arb u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_pend(req_pend),
    .space_ok(space_ok), .pkt_done(pkt_done), .grant(grant), .grant_vld(grant_vld)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 4; s++) mptr[s] = 0;
    mturn = 0; mcnt = 0; qa = 1; qb = 1; mprio = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_pend = '0; space_ok = '0; pkt_done = '0; cfg_we = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    if (!a) mprio = d[NF-1:0];
    else begin
      qa = (d[3:0] == 0) ? 1 : int'(d[3:0]);
      qb = (d[11:8] == 0) ? 1 : int'(d[11:8]);
    end
  endtask

  // Expected winner for eligibility el; updates ratio state (R6 R7 R8 R9 R10)
  task automatic model_pick(input logic [NF-1:0] el);
    int fs[4]; int fi[4]; int g;
    for (int s = 0; s < 4; s++) begin
      logic [NF-1:0] m;
      m = el & ((s >= 2) ? GB : ~GB) & ((s % 2) ? mprio : ~mprio);
      fs[s] = 0; fi[s] = 0;
      for (int k = 0; k < NF; k++) begin
        int j;
        j = (mptr[s] + k) % NF;
        if (fs[s] == 0 && m[j]) begin fs[s] = 1; fi[s] = j; end
      end
    end
    begin
      bit aa, bb;
      aa = (fs[0] | fs[1]) != 0;
      bb = (fs[2] | fs[3]) != 0;
      g = (bb && (!aa || mturn == 1)) ? 1 : 0;
      if (aa && bb) begin
        if (mcnt + 1 >= ((mturn == 1) ? qb : qa)) begin mturn = 1 - mturn; mcnt = 0; end
        else mcnt++;
      end
    end
    mslot = fs[g*2+1] ? g*2+1 : g*2;
    mwin  = fi[mslot];
  endtask

  task automatic finish_pkt();
    pkt_done = '0; pkt_done[mwin] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pkt_done = '0; req_pend = '0;
    mptr[mslot] = (mwin + 1) % NF;
    chk(grant_vld == 1'b0, "R4 release", grant_vld, 0);
  endtask

  initial begin
    logic [15:0] lfsr;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(grant_vld == 1'b0, "R1 vld", grant_vld, 0);
    chk(grant == '0, "R1 grant", grant, 0);
    cfg_addr = 1'b0; #1;
    chk(cfg_rdata == 32'h0, "R1 class reg", cfg_rdata, 0);
    cfg_addr = 1'b1; #1;
    chk(cfg_rdata == 32'h101, "R1 ratio reg", cfg_rdata, 32'h101);

    // R11
    wr(1'b0, 32'hFFFF_FFFF);
    cfg_addr = 1'b0; #1;
    chk(cfg_rdata == 32'h7F, "R11 class bits", cfg_rdata, 32'h7F);
    wr(1'b1, 32'h0000_0000);
    cfg_addr = 1'b1; #1;
    chk(cfg_rdata == 32'h101, "R11 zero count", cfg_rdata, 32'h101);
    wr(1'b1, 32'hFFFF_FFFF);
    cfg_addr = 1'b1; #1;
    chk(cfg_rdata == 32'h0F0F, "R11 ratio fields", cfg_rdata, 32'h0F0F);

    // R2: nothing eligible (requests without space, space without requests)
    do_reset();
    req_pend = 7'h55; space_ok = 7'h2A;
    repeat (3) @(negedge clk);
    chk(grant_vld == 1'b0, "R2 no eligible", grant_vld, 0);

    // R4 R5 R12 directed
    req_pend = 7'b0110000; space_ok = '1;
    model_pick(7'b0110000);
    @(posedge clk); @(negedge clk);
    chk(grant == (NF'(1) << mwin), "R4 first grant", grant, NF'(1) << mwin);
    chk(mwin == 4, "R7 start at pointer", mwin, 4);
    pkt_done = 7'b0100001;
    @(posedge clk); @(negedge clk);
    pkt_done = '0;
    chk(grant == 7'b0010000, "R5 foreign done", grant, 7'b0010000);
    req_pend = '0; space_ok = '0;
    repeat (2) @(negedge clk);
    chk(grant == 7'b0010000, "R4 hold", grant, 7'b0010000);
    wr(1'b0, 32'h20);
    chk(grant == 7'b0010000, "R12 locked write", grant, 7'b0010000);
    space_ok = '1;
    finish_pkt();
    req_pend = 7'b0110000;
    model_pick(7'b0110000);
    @(posedge clk); @(negedge clk);
    chk(grant == 7'b0100000 && mwin == 5, "R12 R6 new class used", grant, 7'b0100000);
    finish_pkt();

    // R9 ratio 3:1 from reset, everything eligible, all low class
    do_reset();
    wr(1'b1, 32'h0000_0103);
    begin
      int na;
      na = 0;
      for (int p = 0; p < 8; p++) begin
        req_pend = '1; space_ok = '1;
        model_pick(7'h7F);
        @(posedge clk); @(negedge clk);
        chk(grant == (NF'(1) << mwin), "R9 R7 ratio grant", grant, NF'(1) << mwin);
        if ((grant & ~GB) != '0) na++;
        chk((((grant & ~GB) != '0) ? 1 : 0) == (((p % 4) != 3) ? 1 : 0), "R9 sequence", grant, p);
        finish_pkt();
      end
      chk(na == 6, "R9 group A count", na, 6);
    end

    // Long sweep: R2 R6 R7 R8 R9 R10
    do_reset();
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      logic [NF-1:0] el;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req_pend = '0;
      if (i % 7 == 0) wr(1'b0, {25'd0, lfsr[15:9]});
      if (i % 53 == 0) wr(1'b1, {20'd0, 1'b0, lfsr[2:0], 5'd0, lfsr[5:3]});
      req_pend = lfsr[6:0] | lfsr[13:7];
      space_ok = ~(lfsr[12:6] & lfsr[11:5]);
      el = req_pend & space_ok;
      if (el == '0) begin
        @(posedge clk); @(negedge clk);
        chk(grant_vld == 1'b0, "R2 idle", grant_vld, 0);
        req_pend = '0;
      end else begin
        model_pick(el);
        @(posedge clk); @(negedge clk);
        chk(grant == (NF'(1) << mwin), "R2 R6 R7 R8 R9 R10 winner", grant, NF'(1) << mwin);
        finish_pkt();
      end
    end

    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule